// File: doc/BRIEF.md
# BCH Sector Error Location Mapper

This block sits after a BCH locator in a NAND read path and applies its results to one 512-byte sector protected by an 8-bit-correcting or a 16-bit-correcting BCH code. For each sector it takes in the computed syndrome bytes and the ECC bytes stored in the spare area, one pair per cycle. If the syndrome is all zero, the sector is clean. If the stored ECC is all 0xFF, the sector is freshly erased. In both cases it finishes at once and changes nothing.

Otherwise it plays the syndrome back in reverse byte order, which is the order the locator expects. It then waits for the locator's error count and pops the locations from a show-ahead FIFO. Each location counts bits backwards from the end of the combined data-plus-ECC codeword. The block turns each location into a byte and a bit. It then read-modify-writes the byte in the sector data buffer or in the spare ECC buffer, or flags the location as impossible.

Top module: `bch_errloc_mapper`

## Requirements
- R1: When all N syndrome bytes of a sector are zero, the block makes no buffer access and produces no replay. It pulses done with an error count of 0 and the invalid flag low.
- R2: When all N stored ECC bytes are 0xFF, the block takes the same bypass as in R1. This holds whatever the syndrome is.
- R3: Input mode selects the code: 0 for the 8-bit code with N = 13 and a codeword limit L = 525, and 1 for the 16-bit code with N = 26 and L = 538. The byte position of location x is L - 1 - floor(x/8), and the bit position is x mod 8.
- R4: A byte position below 512 inverts that bit of the data buffer byte at that address. The write goes to the address read in the previous cycle.
- R5: A byte position from 512 up to L - 1 inverts that bit of the spare buffer byte at position minus 512.
- R6: A location with floor(x/8) >= L makes no buffer access and sets the invalid flag. The other locations of the same sector are still corrected.
- R7: A sector that is neither clean nor erased has its N syndrome bytes replayed in reverse order, one per cycle. The replay starts two cycles after the last input byte.
- R8: On done, the error count equals the number of locations when none was invalid, and 0 when any was invalid.
- R9: Done is a one-cycle pulse. It comes 2 cycles after the last input byte for a bypassed sector, and 2K+1 cycles after the count strobe for K locations, with K = 0 allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a sector; accepted only when idle |
| mode | input | 1 | 0 = 8-bit code, 1 = 16-bit code |
| in_valid | input | 1 | Syndrome and stored-ECC byte pair valid |
| syn_byte | input | 8 | Computed syndrome byte |
| secc_byte | input | 8 | Stored ECC byte from the spare area |
| rev_valid | output | 1 | Reversed syndrome byte valid |
| rev_byte | output | 8 | Reversed syndrome byte to the locator |
| loc_cnt_valid | input | 1 | Error count strobe from the locator |
| loc_cnt | input | CNT_W | Number of locations to process |
| loc_empty | input | 1 | Location FIFO empty |
| loc_data | input | LOC_W | Head location of the FIFO (show-ahead) |
| loc_pop | output | 1 | Consume the head location |
| dbuf_rd_en | output | 1 | Data buffer read, data due next cycle |
| dbuf_wr_en | output | 1 | Data buffer write |
| dbuf_addr | output | 9 | Data buffer byte address |
| dbuf_wdata | output | 8 | Corrected data byte |
| dbuf_rdata | input | 8 | Data buffer read data |
| sbuf_rd_en | output | 1 | Spare buffer read, data due next cycle |
| sbuf_wr_en | output | 1 | Spare buffer write |
| sbuf_addr | output | 5 | Spare buffer byte address |
| sbuf_wdata | output | 8 | Corrected spare byte |
| sbuf_rdata | input | 8 | Spare buffer read data |
| done | output | 1 | Sector finished pulse |
| err_count | output | CNT_W | Corrected bit count, held until the next done |
| loc_invalid | output | 1 | At least one impossible location, held |

## Verification
The screening decision is registered one cycle after the last byte pair. A bypass therefore shows done on the second cycle after that byte. A dirty sector instead starts its reverse replay in that same cycle and finishes N cycles later. In the correction loop, each location takes a read cycle and then a write cycle, and done follows the final write. The count strobe thus leads done by exactly 2K+1 cycles. The bench drives on the falling edge and counts falling edges from each stimulus until done. It compares that count with the figure above. It compares the replay and both buffer images only after done, against copies updated arithmetically from the same location list.

// File: rtl/eloc_pkg.sv
package eloc_pkg;

  typedef enum logic {CODE_T8 = 1'b0, CODE_T16 = 1'b1} code_e;

  // Number of ECC bytes that take part in the codeword for a code.
  function automatic int ecc_len(input logic t16, input int e8, input int e16);
    return t16 ? e16 : e8;
  endfunction

  // Codeword length in bytes: sector data plus the active ECC bytes.
  function automatic int cw_limit(input logic t16, input int sect, input int e8, input int e16);
    return sect + ecc_len(t16, e8, e16);
  endfunction

  // A location is impossible when its byte lies before the codeword start.
  function automatic logic loc_beyond(input int loc, input int lim);
    return (loc / 8) >= lim;
  endfunction

  // Locations count bits from the codeword end.
  function automatic int loc_byte(input int loc, input int lim);
    return lim - 1 - (loc / 8);
  endfunction

  function automatic int loc_bit(input int loc);
    return loc % 8;
  endfunction

endpackage

// File: rtl/eloc_screen.sv
module eloc_screen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic [7:0] syn_byte,
  input  logic [7:0] secc_byte,
  output logic       all_zero,
  output logic       all_ff
);

  logic zero_q, ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b1;
      ff_q   <= 1'b1;
    end else if (clear) begin
      zero_q <= 1'b1;
      ff_q   <= 1'b1;
    end else if (take) begin
      zero_q <= zero_q & (syn_byte == 8'h00);
      ff_q   <= ff_q & (secc_byte == 8'hFF);
    end
  end

  assign all_zero = zero_q;
  assign all_ff   = ff_q;

endmodule

// File: rtl/eloc_reverser.sv
module eloc_reverser #(
  parameter int DEPTH = 26,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             load,
  input  logic             step,
  output logic [IDX_W-1:0] fill,
  output logic [7:0]       tail_byte,
  output logic             at_head
);

  logic [7:0]       store [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;

  always_ff @(posedge clk) begin
    if (push && (int'(wr_idx) < DEPTH)) store[wr_idx] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (clear)     wr_idx <= '0;
      else if (push) wr_idx <= wr_idx + 1'b1;
      if (load)      rd_idx <= wr_idx - 1'b1;
      else if (step) rd_idx <= rd_idx - 1'b1;
    end
  end

  assign fill      = wr_idx;
  assign tail_byte = store[rd_idx];
  assign at_head   = (rd_idx == '0);

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(wr_idx) < DEPTH));

endmodule

// File: rtl/eloc_fixer.sv
module eloc_fixer import eloc_pkg::*; #(
  parameter int SECT_BYTES  = 512,
  parameter int ECC8_BYTES  = 13,
  parameter int ECC16_BYTES = 26,
  parameter int LOC_W       = 13,
  parameter int CNT_W       = 5,
  parameter int DADDR_W     = 9,
  parameter int SADDR_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   count,
  input  code_e              code,
  input  logic               loc_empty,
  input  logic [LOC_W-1:0]   loc_data,
  output logic               loc_pop,
  output logic               dbuf_rd_en,
  output logic               dbuf_wr_en,
  output logic [DADDR_W-1:0] dbuf_addr,
  output logic [7:0]         dbuf_wdata,
  input  logic [7:0]         dbuf_rdata,
  output logic               sbuf_rd_en,
  output logic               sbuf_wr_en,
  output logic [SADDR_W-1:0] sbuf_addr,
  output logic [7:0]         sbuf_wdata,
  input  logic [7:0]         sbuf_rdata,
  output logic               fin,
  output logic               bad
);

  typedef enum logic [1:0] {F_IDLE, F_RD, F_WR} fst_e;

  fst_e               st;
  logic [CNT_W-1:0]   rem;
  logic               bad_q, ok_q, spare_q;
  logic [2:0]         bit_q;
  logic [DADDR_W-1:0] daddr_q;
  logic [SADDR_W-1:0] saddr_q;

  int                 lim, bpos;
  logic               now_bad, now_spare;
  logic [DADDR_W-1:0] daddr_now;
  logic [SADDR_W-1:0] saddr_now;
  logic [2:0]         bit_now;

  always_comb begin
    lim       = cw_limit(code == CODE_T16, SECT_BYTES, ECC8_BYTES, ECC16_BYTES);
    now_bad   = loc_beyond(int'(loc_data), lim);
    bpos      = loc_byte(int'(loc_data), lim);
    now_spare = !now_bad && (bpos >= SECT_BYTES);
    daddr_now = DADDR_W'(bpos);
    saddr_now = SADDR_W'(bpos - SECT_BYTES);
    bit_now   = 3'(loc_bit(int'(loc_data)));
  end

  // named events for the checks below
  wire rd_step = (st == F_RD) && !loc_empty;
  wire wr_step = (st == F_WR);
  wire [7:0] flip_mask = 8'd1 << bit_q;

  assign loc_pop    = rd_step;
  assign dbuf_rd_en = rd_step && !now_bad && !now_spare;
  assign sbuf_rd_en = rd_step && now_spare;
  assign dbuf_addr  = (st == F_RD) ? daddr_now : daddr_q;
  assign sbuf_addr  = (st == F_RD) ? saddr_now : saddr_q;
  assign dbuf_wr_en = wr_step && ok_q && !spare_q;
  assign sbuf_wr_en = wr_step && ok_q && spare_q;
  assign dbuf_wdata = dbuf_rdata ^ flip_mask;
  assign sbuf_wdata = sbuf_rdata ^ flip_mask;
  assign fin        = wr_step && (rem == CNT_W'(1));
  assign bad        = bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      rem     <= '0;
      bad_q   <= 1'b0;
      ok_q    <= 1'b0;
      spare_q <= 1'b0;
      bit_q   <= '0;
      daddr_q <= '0;
      saddr_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          rem   <= count;
          bad_q <= 1'b0;
          st    <= F_RD;
        end
        F_RD: if (rd_step) begin
          ok_q    <= !now_bad;
          spare_q <= now_spare;
          bit_q   <= bit_now;
          daddr_q <= daddr_now;
          saddr_q <= saddr_now;
          if (now_bad) bad_q <= 1'b1;
          st      <= F_WR;
        end
        F_WR: begin
          rem <= rem - 1'b1;
          st  <= (rem == CNT_W'(1)) ? F_IDLE : F_RD;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_data_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_wr_en |-> $past(dbuf_rd_en));
  assert_data_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_wr_en |-> (dbuf_addr == $past(dbuf_addr)));
  assert_spare_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sbuf_wr_en |-> ($past(sbuf_rd_en) && (sbuf_addr == $past(sbuf_addr))));
  assert_spare_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sbuf_rd_en |-> (int'(sbuf_addr) < lim - SECT_BYTES));

endmodule

// File: rtl/bch_errloc_mapper.sv
module bch_errloc_mapper import eloc_pkg::*; #(
  parameter int SECT_BYTES  = 512,
  parameter int ECC8_BYTES  = 13,
  parameter int ECC16_BYTES = 26,
  parameter int LOC_W       = 13,
  parameter int CNT_W       = 5,
  localparam int DADDR_W    = $clog2(SECT_BYTES),
  localparam int SADDR_W    = $clog2(ECC16_BYTES),
  localparam int IDX_W      = $clog2(ECC16_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode,
  input  logic               in_valid,
  input  logic [7:0]         syn_byte,
  input  logic [7:0]         secc_byte,
  output logic               rev_valid,
  output logic [7:0]         rev_byte,
  input  logic               loc_cnt_valid,
  input  logic [CNT_W-1:0]   loc_cnt,
  input  logic               loc_empty,
  input  logic [LOC_W-1:0]   loc_data,
  output logic               loc_pop,
  output logic               dbuf_rd_en,
  output logic               dbuf_wr_en,
  output logic [DADDR_W-1:0] dbuf_addr,
  output logic [7:0]         dbuf_wdata,
  input  logic [7:0]         dbuf_rdata,
  output logic               sbuf_rd_en,
  output logic               sbuf_wr_en,
  output logic [SADDR_W-1:0] sbuf_addr,
  output logic [7:0]         sbuf_wdata,
  input  logic [7:0]         sbuf_rdata,
  output logic               done,
  output logic [CNT_W-1:0]   err_count,
  output logic               loc_invalid
);

  typedef enum logic [2:0] {T_IDLE, T_FILL, T_DECIDE, T_REPLAY, T_WAITCNT, T_FIX} tst_e;

  tst_e             st;
  code_e            code_q;
  logic [CNT_W-1:0] cnt_q, err_q;
  logic             done_q, inv_q;
  logic [IDX_W-1:0] fill;
  logic             all_zero, all_ff, at_head, fix_fin, fix_bad;

  wire [IDX_W-1:0] nbytes = IDX_W'(ecc_len(code_q == CODE_T16, ECC8_BYTES, ECC16_BYTES));
  wire clear     = (st == T_IDLE) && start;
  wire take      = (st == T_FILL) && in_valid;
  wire last_in   = take && (fill == nbytes - 1'b1);
  wire bypass    = all_zero || all_ff;
  wire rd_load   = (st == T_DECIDE) && !bypass;
  wire rd_step   = (st == T_REPLAY);
  wire fix_start = (st == T_WAITCNT) && loc_cnt_valid && (loc_cnt != '0);

  eloc_screen u_screen (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take),
    .syn_byte(syn_byte), .secc_byte(secc_byte),
    .all_zero(all_zero), .all_ff(all_ff)
  );

  eloc_reverser #(.DEPTH(ECC16_BYTES), .IDX_W(IDX_W)) u_rev (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push(take), .push_byte(syn_byte),
    .load(rd_load), .step(rd_step), .fill(fill), .tail_byte(rev_byte), .at_head(at_head)
  );

  eloc_fixer #(
    .SECT_BYTES(SECT_BYTES), .ECC8_BYTES(ECC8_BYTES), .ECC16_BYTES(ECC16_BYTES),
    .LOC_W(LOC_W), .CNT_W(CNT_W), .DADDR_W(DADDR_W), .SADDR_W(SADDR_W)
  ) u_fix (
    .clk(clk), .rst_n(rst_n), .start(fix_start), .count(loc_cnt), .code(code_q),
    .loc_empty(loc_empty), .loc_data(loc_data), .loc_pop(loc_pop),
    .dbuf_rd_en(dbuf_rd_en), .dbuf_wr_en(dbuf_wr_en), .dbuf_addr(dbuf_addr),
    .dbuf_wdata(dbuf_wdata), .dbuf_rdata(dbuf_rdata),
    .sbuf_rd_en(sbuf_rd_en), .sbuf_wr_en(sbuf_wr_en), .sbuf_addr(sbuf_addr),
    .sbuf_wdata(sbuf_wdata), .sbuf_rdata(sbuf_rdata),
    .fin(fix_fin), .bad(fix_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      code_q <= CODE_T8;
      cnt_q  <= '0;
      err_q  <= '0;
      inv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          code_q <= code_e'(mode);
          st     <= T_FILL;
        end
        T_FILL: if (last_in) st <= T_DECIDE;
        T_DECIDE: if (bypass) begin
          done_q <= 1'b1;
          err_q  <= '0;
          inv_q  <= 1'b0;
          st     <= T_IDLE;
        end else begin
          st <= T_REPLAY;
        end
        T_REPLAY: if (at_head) st <= T_WAITCNT;
        T_WAITCNT: if (loc_cnt_valid) begin
          if (loc_cnt == '0) begin
            done_q <= 1'b1;
            err_q  <= '0;
            inv_q  <= 1'b0;
            st     <= T_IDLE;
          end else begin
            cnt_q <= loc_cnt;
            st    <= T_FIX;
          end
        end
        T_FIX: if (fix_fin) begin
          done_q <= 1'b1;
          err_q  <= fix_bad ? '0 : cnt_q;
          inv_q  <= fix_bad;
          st     <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign rev_valid   = rd_step;
  assign done        = done_q;
  assign err_count   = err_q;
  assign loc_invalid = inv_q;

  assert_bypass_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == T_DECIDE) && bypass) |=> (done && (err_count == '0) && !loc_invalid));
  assert_replay_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid |-> !(all_zero || all_ff));
  assert_invalid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && loc_invalid) |-> (err_count == '0));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_bch_errloc_mapper.sv
module sim_bch_errloc_mapper;
  localparam int SB = 512, E8 = 13, E16 = 26, LW = 13, CW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, mode = 1'b0, in_valid = 1'b0;
  logic [7:0] syn_byte = '0, secc_byte = '0;
  logic rev_valid; logic [7:0] rev_byte;
  logic loc_cnt_valid = 1'b0; logic [CW-1:0] loc_cnt = '0;
  logic loc_empty; logic [LW-1:0] loc_data; logic loc_pop;
  logic dbuf_rd_en, dbuf_wr_en, sbuf_rd_en, sbuf_wr_en;
  logic [8:0] dbuf_addr; logic [4:0] sbuf_addr;
  logic [7:0] dbuf_wdata, sbuf_wdata, dbuf_rdata, sbuf_rdata;
  logic done, loc_invalid; logic [CW-1:0] err_count;

  bch_errloc_mapper u0 (.*);

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] dmem [SB], smem [E16], dexp [SB], sexp [E16];
  logic [7:0] rbuf [64];
  int fq [64];
  int fhead = 0, ftail = 0, rtotal = 0;
  int lq [8];

  assign loc_empty = (fhead == ftail);
  assign loc_data  = LW'(fq[fhead & 63]);

  always @(posedge clk) begin
    if (dbuf_rd_en) dbuf_rdata <= dmem[dbuf_addr];
    if (dbuf_wr_en) dmem[dbuf_addr] <= dbuf_wdata;
    if (sbuf_rd_en) sbuf_rdata <= smem[sbuf_addr];
    if (sbuf_wr_en) smem[sbuf_addr] <= sbuf_wdata;
    if (loc_pop) fhead <= fhead + 1;
    if (rev_valid) begin
      rbuf[rtotal & 63] <= rev_byte;
      rtotal <= rtotal + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sv(input int i, input int seed);
    return 8'((i * 29 + seed) | 1);
  endfunction

  task automatic run(input bit md, input bit zs, input bit ff, input int k, input string tag);
    int n, lim, base, lat, seed, w, mis;
    bit expbad, byp;
    n = md ? E16 : E8;
    lim = SB + n;
    seed = k * 11 + lq[0];
    byp = zs | ff;
    expbad = 0;
    if (!byp) begin
      for (int j = 0; j < k; j++) begin
        int q, bp, b;
        fq[(ftail + j) & 63] = lq[j];
        q = lq[j] / 8; b = lq[j] % 8;
        if (q >= lim) expbad = 1;
        else begin
          bp = lim - 1 - q;
          if (bp < SB) dexp[bp] ^= 8'(1 << b);
          else sexp[bp - SB] ^= 8'(1 << b);
        end
      end
      ftail = ftail + k;
    end
    base = rtotal;
    start = 1'b1; mode = md;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      syn_byte = zs ? 8'h00 : sv(i, seed);
      secc_byte = ff ? 8'hFF : 8'(i * 7);
      @(negedge clk);
    end
    in_valid = 1'b0;
    lat = 1;
    if (byp) begin
      while (!done && lat < 60) begin @(negedge clk); lat++; end
      chk(lat == 2, zs ? "R1" : "R2", {tag, " bypass latency"}, lat, 2);
      chk(rtotal == base, zs ? "R1" : "R2", {tag, " no replay"}, rtotal - base, 0);
    end else begin
      w = 0;
      while ((rtotal - base) < n && w < 100) begin @(negedge clk); w++; end
      mis = 0;
      for (int j = 0; j < n; j++) if (rbuf[(base + j) & 63] !== sv(n - 1 - j, seed)) mis++;
      chk((rtotal - base == n) && mis == 0, "R7", {tag, " reversed replay mismatches"}, mis, 0);
      chk(w == n + 1, "R7", {tag, " replay end cycle"}, w, n + 1);
      loc_cnt_valid = 1'b1; loc_cnt = CW'(k);
      @(negedge clk);
      loc_cnt_valid = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      chk(lat == 2 * k + 1, "R9", {tag, " done after count"}, lat, 2 * k + 1);
    end
    chk(int'(err_count) == ((byp || expbad) ? 0 : k), "R8", {tag, " err_count"},
        int'(err_count), (byp || expbad) ? 0 : k);
    chk(loc_invalid == expbad, "R6", {tag, " invalid flag"}, int'(loc_invalid), int'(expbad));
    mis = 0;
    for (int i = 0; i < SB; i++) if (dmem[i] !== dexp[i]) mis++;
    chk(mis == 0, "R4", {tag, " data buffer mismatches"}, mis, 0);
    mis = 0;
    for (int i = 0; i < E16; i++) if (smem[i] !== sexp[i]) mis++;
    chk(mis == 0, "R5", {tag, " spare buffer mismatches"}, mis, 0);
    @(negedge clk);
    chk(!done, "R9", {tag, " done single pulse"}, int'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SB; i++) begin dmem[i] = 8'(i * 3 + 1); dexp[i] = 8'(i * 3 + 1); end
    for (int i = 0; i < E16; i++) begin smem[i] = 8'(i * 5 + 2); sexp[i] = 8'(i * 5 + 2); end
    for (int i = 0; i < 8; i++) lq[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && err_count == '0 && !loc_invalid, "R9", "reset outputs", int'(done), 0);
    chk(!loc_pop && !rev_valid && !dbuf_wr_en && !sbuf_wr_en, "R7", "reset idle strobes",
        int'(loc_pop), 0);

    // R1 clean sectors, R2 erased sectors, both codes
    run(1'b0, 1'b1, 1'b0, 0, "clean t8");
    run(1'b1, 1'b1, 1'b0, 0, "clean t16");
    run(1'b0, 1'b0, 1'b1, 0, "erased t8");
    run(1'b1, 1'b0, 1'b1, 0, "erased t16");

    // R9 empty location list
    run(1'b0, 1'b0, 1'b0, 0, "zero count");

    // R3/R4/R5 several locations, two in one spare byte, one at data byte 0
    lq[0] = 100; lq[1] = 101; lq[2] = 4199; lq[3] = 0;
    run(1'b0, 1'b0, 1'b0, 4, "multi t8");

    // R6 invalid mixed with valid locations
    lq[0] = 0; lq[1] = 4303; lq[2] = 4304;
    run(1'b1, 1'b0, 1'b0, 3, "mixed invalid t16");

    // R3 sweep of single locations across and past each codeword
    for (int md = 0; md < 2; md++) begin
      int lim;
      lim = SB + (md ? E16 : E8);
      for (int loc = 0; loc < lim * 8 + 24; loc += 5) begin
        lq[0] = loc;
        run(md[0], 1'b0, 1'b0, 1, md ? "sweep R3 t16" : "sweep R3 t8");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule